// File: doc/BRIEF.md
# Thread-Block Dispatcher for Parallel Compute Units

This block takes a stream of work-group descriptors and places each one on one of several compute units. A descriptor carries an identifier, a thread count, a per-thread register count and a shared-memory byte count. For every unit the dispatcher tracks five free resources: resident-block slots, warp slots, thread slots, registers and shared-memory bytes. A descriptor is placed on a unit only when all five fit at once. The placement subtracts the amounts from that unit. The work group stays on that unit until the unit reports it finished. The finish report returns exactly the amounts that were subtracted.

Descriptors are consumed strictly in order. If the head descriptor fits on no unit, the queue stalls until a completion frees space. If a descriptor could never fit even an empty unit, it is dropped and a one-cycle error pulse is raised. Units are searched in round-robin order, starting just after the last unit that received work. At most one placement is made per cycle.

Top module: `block_dispatcher`

## Requirements
- R1: The warp demand of a descriptor is its thread count divided by WARP_SIZE (32), rounded up. A 65-thread descriptor therefore takes 3 warp slots, and at most 21 of them fit a 64-warp unit.
- R2: A descriptor is placed on a unit only if the unit has at least 1 free block slot and enough free warps, threads, registers and shared-memory bytes. Placement subtracts all five amounts. Per-unit limits are 32 blocks, 64 warps, 2048 threads and 65536 registers, with a shared-memory capacity parameter (default 49152).
- R3: A pulse on `done_i[u]` with identifier `done_id_i[u*ID_W +: ID_W]` returns to unit u exactly the five amounts deducted when that identifier was placed there.
- R4: Units are searched in round-robin order, starting at the unit after the one that last received a placement. At most one bit of `grant_vld_o` is set in any cycle.
- R5: Dispatch is in order. When the head descriptor fits on no unit, `req_ready_o` is low and no placement occurs until space is freed.
- R6: A descriptor with zero threads, or whose demand exceeds an empty unit's capacity in any of the five resources, is accepted (`req_ready_o` high), dropped, and flagged by `reject_o` one cycle later. No placement occurs for it.
- R7: A completion and a placement on the same unit in the same cycle are both applied. Fit is judged on the free amounts before that cycle's release.
- R8: After reset every unit is empty, `grant_vld_o` and `reject_o` are low, and the first placement goes to unit 0.
- R9: The register demand of a descriptor is its thread count times its registers per thread. Thus 256 threads at 64 registers each allow at most 4 resident blocks per unit.
- R10: A placement accepted at a clock edge appears on `grant_vld_o[u]` and `grant_id_o` for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Head descriptor present |
| req_ready_o | output | 1 | Head descriptor consumed this cycle (placed or dropped) |
| req_id_i | input | ID_W | Work-group identifier |
| req_thr_i | input | THR_W | Threads in the work group |
| req_rpt_i | input | RPT_W | Registers per thread |
| req_smem_i | input | SMEM_W | Shared-memory bytes for the work group |
| grant_vld_o | output | NUM_CU | One-hot placement strobe, bit u for unit u |
| grant_id_o | output | ID_W | Identifier of the placed work group |
| reject_o | output | 1 | Oversized descriptor dropped |
| done_i | input | NUM_CU | Completion strobe per unit |
| done_id_i | input | NUM_CU*ID_W | Completed identifier per unit, unit u in bits u*ID_W +: ID_W |

## Verification
The embedded assertions watch several properties on every cycle. They check that no unit's free amount exceeds its limit, that a placement only goes to a unit reporting a fit, and that at most one unit is granted per cycle. They also check that a completion returns a block slot, or leaves the count unchanged when a placement coincides, and that a stalled head causes no placement or reject. Other properties depend on the exact sequence of amounts across many placements and releases: warp rounding, the register product, the round-robin start point, and exact restoration on completion. Only the bench scenarios show these. The scenarios fill units to their warp, register and shared-memory limits, drain them, and mix random sizes with oversized descriptors against a behavioural model.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int BLK_W  = 6;
  localparam int THR_W  = 12;
  localparam int RPT_W  = 8;
  localparam int WARP_W = 8;
  localparam int REG_W  = THR_W + RPT_W;
  localparam int SMEM_W = 18;

  typedef struct packed {
    logic [WARP_W-1:0] warps;
    logic [THR_W-1:0]  thr;
    logic [REG_W-1:0]  regs;
    logic [SMEM_W-1:0] smem;
  } demand_t;
endpackage

// File: rtl/dsp_demand.sv
module dsp_demand
  import dsp_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int MAX_WARP  = 64,
  parameter int MAX_THR   = 2048,
  parameter int MAX_REG   = 65536,
  parameter int MAX_SMEM  = 49152
) (
  input  logic [THR_W-1:0]  thr_i,
  input  logic [RPT_W-1:0]  rpt_i,
  input  logic [SMEM_W-1:0] smem_i,
  output demand_t           dem_o,
  output logic              oversize_o
);
  localparam int LANE_SH = $clog2(WARP_SIZE);

  logic [THR_W:0] thr_rnd;

  always_comb begin
    thr_rnd     = {1'b0, thr_i} + (THR_W+1)'(WARP_SIZE - 1);
    dem_o.warps = WARP_W'(thr_rnd >> LANE_SH);
    dem_o.thr   = thr_i;
    dem_o.regs  = REG_W'(thr_i) * REG_W'(rpt_i);
    dem_o.smem  = smem_i;
    oversize_o  = (thr_i == '0)
               || (int'(dem_o.warps) > MAX_WARP)
               || (int'(thr_i) > MAX_THR)
               || (int'(dem_o.regs) > MAX_REG)
               || (int'(smem_i) > MAX_SMEM);
  end
endmodule

// File: rtl/dsp_ledger.sv
module dsp_ledger
  import dsp_pkg::*;
#(
  parameter int ID_W     = 7,
  parameter int MAX_BLK  = 32,
  parameter int MAX_WARP = 64,
  parameter int MAX_THR  = 2048,
  parameter int MAX_REG  = 65536,
  parameter int MAX_SMEM = 49152
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  demand_t         dem_i,
  input  logic            grant_i,
  input  logic [ID_W-1:0] grant_id_i,
  input  logic            done_i,
  input  logic [ID_W-1:0] done_id_i,
  output logic            fit_o
);
  localparam int NID = 1 << ID_W;

  logic [BLK_W-1:0]  f_blk;
  logic [WARP_W-1:0] f_warp;
  logic [THR_W-1:0]  f_thr;
  logic [REG_W-1:0]  f_reg;
  logic [SMEM_W-1:0] f_smem;

  demand_t         tbl_q [NID];
  logic [NID-1:0]  resident_q;
  demand_t         rel;
  demand_t         take;

  always_comb begin
    rel   = done_i  ? tbl_q[done_id_i] : '0;
    take  = grant_i ? dem_i            : '0;
    fit_o = (f_blk != '0)
         && (f_warp >= dem_i.warps)
         && (f_thr  >= dem_i.thr)
         && (f_reg  >= dem_i.regs)
         && (f_smem >= dem_i.smem);
  end

  // release first, then deduct; net change applied in one step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_blk      <= BLK_W'(MAX_BLK);
      f_warp     <= WARP_W'(MAX_WARP);
      f_thr      <= THR_W'(MAX_THR);
      f_reg      <= REG_W'(MAX_REG);
      f_smem     <= SMEM_W'(MAX_SMEM);
      resident_q <= '0;
    end else begin
      f_blk  <= f_blk  + BLK_W'(done_i) - BLK_W'(grant_i);
      f_warp <= f_warp + rel.warps - take.warps;
      f_thr  <= f_thr  + rel.thr   - take.thr;
      f_reg  <= f_reg  + rel.regs  - take.regs;
      f_smem <= f_smem + rel.smem  - take.smem;
      if (done_i)  resident_q[done_id_i]  <= 1'b0;
      if (grant_i) resident_q[grant_id_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (grant_i) tbl_q[grant_id_i] <= dem_i;
  end

  AST_GRANT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> fit_o); // R2
  AST_FREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(f_blk) <= MAX_BLK) && (int'(f_warp) <= MAX_WARP) && (int'(f_thr) <= MAX_THR)
    && (int'(f_reg) <= MAX_REG) && (int'(f_smem) <= MAX_SMEM)); // R2
  AST_DONE_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> resident_q[done_id_i]); // R3
  AST_SLOT_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !grant_i |=> f_blk == $past(f_blk) + 1'b1); // R3
  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && grant_i |=> f_blk == $past(f_blk)); // R7
endmodule

// File: rtl/dsp_rr_pick.sv
module dsp_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     fit_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [N-1:0]     sel_oh_o
);
  always_comb begin
    int idx;
    hit_o    = 1'b0;
    sel_o    = '0;
    sel_oh_o = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_i) + k) % N;
      if (!hit_o && fit_i[idx]) begin
        hit_o         = 1'b1;
        sel_o         = IDX_W'(idx);
        sel_oh_o[idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import dsp_pkg::*;
#(
  parameter int NUM_CU    = 4,
  parameter int ID_W      = 7,
  parameter int WARP_SIZE = 32,
  parameter int MAX_BLK   = 32,
  parameter int MAX_WARP  = 64,
  parameter int MAX_THR   = 2048,
  parameter int MAX_REG   = 65536,
  parameter int MAX_SMEM  = 49152,
  localparam int IDX_W    = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ID_W-1:0]        req_id_i,
  input  logic [THR_W-1:0]       req_thr_i,
  input  logic [RPT_W-1:0]       req_rpt_i,
  input  logic [SMEM_W-1:0]      req_smem_i,
  output logic [NUM_CU-1:0]      grant_vld_o,
  output logic [ID_W-1:0]        grant_id_o,
  output logic                   reject_o,
  input  logic [NUM_CU-1:0]      done_i,
  input  logic [NUM_CU*ID_W-1:0] done_id_i
);
  demand_t           dem;
  logic              oversize;
  logic [NUM_CU-1:0] fit;
  logic [NUM_CU-1:0] sel_oh;
  logic [NUM_CU-1:0] grant;
  logic [IDX_W-1:0]  sel;
  logic [IDX_W-1:0]  last_q;
  logic              hit;
  logic              accept;

  dsp_demand #(
    .WARP_SIZE(WARP_SIZE), .MAX_WARP(MAX_WARP), .MAX_THR(MAX_THR),
    .MAX_REG(MAX_REG), .MAX_SMEM(MAX_SMEM)
  ) u_demand (
    .thr_i(req_thr_i), .rpt_i(req_rpt_i), .smem_i(req_smem_i),
    .dem_o(dem), .oversize_o(oversize)
  );

  for (genvar u = 0; u < NUM_CU; u++) begin : g_cu
    dsp_ledger #(
      .ID_W(ID_W), .MAX_BLK(MAX_BLK), .MAX_WARP(MAX_WARP),
      .MAX_THR(MAX_THR), .MAX_REG(MAX_REG), .MAX_SMEM(MAX_SMEM)
    ) u_ledger (
      .clk_i(clk_i), .rst_ni(rst_ni), .dem_i(dem),
      .grant_i(grant[u]), .grant_id_i(req_id_i),
      .done_i(done_i[u]), .done_id_i(done_id_i[u*ID_W +: ID_W]),
      .fit_o(fit[u])
    );
  end

  dsp_rr_pick #(.N(NUM_CU), .IDX_W(IDX_W)) u_pick (
    .fit_i(fit), .last_i(last_q), .hit_o(hit), .sel_o(sel), .sel_oh_o(sel_oh)
  );

  assign req_ready_o = oversize || hit;
  assign accept      = req_valid_i && !oversize && hit;
  assign grant       = accept ? sel_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q      <= IDX_W'(NUM_CU - 1);
      grant_vld_o <= '0;
      grant_id_o  <= '0;
      reject_o    <= 1'b0;
    end else begin
      if (accept) last_q <= sel;
      grant_vld_o <= grant;
      grant_id_o  <= req_id_i;
      reject_o    <= req_valid_i && oversize;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_vld_o)); // R4
  AST_REJECT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> grant_vld_o == '0); // R6
  AST_DROP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && oversize |=> reject_o); // R6
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_o |=> grant_vld_o == '0 && !reject_o); // R5
endmodule

// File: tb/tb_block_dispatcher.sv
module tb_block_dispatcher;
  localparam int NCU  = 4;
  localparam int IDW  = 7;
  localparam int NID  = 1 << IDW;
  localparam int MBLK = 32, MWARP = 64, MTHR = 2048, MREG = 65536, MSMEM = 49152;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [IDW-1:0]   req_id_i = '0;
  logic [11:0]      req_thr_i = '0;
  logic [7:0]       req_rpt_i = '0;
  logic [17:0]      req_smem_i = '0;
  logic [NCU-1:0]   grant_vld_o;
  logic [IDW-1:0]   grant_id_o;
  logic             reject_o;
  logic [NCU-1:0]   done_i = '0;
  logic [NCU*IDW-1:0] done_id_i = '0;

  always #10 clk = ~clk;

  block_dispatcher #(.NUM_CU(NCU), .ID_W(IDW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_id_i(req_id_i), .req_thr_i(req_thr_i), .req_rpt_i(req_rpt_i),
    .req_smem_i(req_smem_i), .grant_vld_o(grant_vld_o), .grant_id_o(grant_id_o),
    .reject_o(reject_o), .done_i(done_i), .done_id_i(done_id_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  int fb[NCU], fw[NCU], ft[NCU], fr[NCU], fs[NCU];
  int tw[NCU][NID], tt[NCU][NID], tr[NCU][NID], ts[NCU][NID];
  bit res[NCU][NID];
  bit idused[NID];
  int last;
  int exp_gv, exp_gid, exp_rej;

  bit have;
  int d_id, d_thr, d_rpt, d_smem;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // phase: 0 fill65, 2 fill reg, 4 fill smem, 6 random; odd = drain
  function automatic int phase_of(int cyc);
    if (cyc < 400)  return 0;
    if (cyc < 800)  return 1;
    if (cyc < 1200) return 2;
    if (cyc < 1600) return 3;
    if (cyc < 2000) return 4;
    if (cyc < 2400) return 5;
    if (cyc < 6000) return 6;
    return 7;
  endfunction

  initial begin
    int ph, prev_ph;
    for (int u = 0; u < NCU; u++) begin
      fb[u] = MBLK; fw[u] = MWARP; ft[u] = MTHR; fr[u] = MREG; fs[u] = MSMEM;
      for (int i = 0; i < NID; i++) res[u][i] = 0;
    end
    for (int i = 0; i < NID; i++) idused[i] = 0;
    last = NCU - 1; exp_gv = 0; exp_gid = 0; exp_rej = 0; have = 0;
    repeat (3) @(negedge clk);
    chk(grant_vld_o == '0, "R8 reset grant", int'(grant_vld_o), 0);
    chk(reject_o == 1'b0, "R8 reset reject", int'(reject_o), 0);
    rst_ni = 1'b1;
    prev_ph = 0;
    for (int cyc = 0; cyc < 6400; cyc++) begin
      int w, rg, pick, ovs;
      bit fits[NCU];
      @(negedge clk);
      chk(int'(grant_vld_o) == exp_gv, "R4 R8 R10 grant unit", int'(grant_vld_o), exp_gv);
      if (exp_gv != 0)
        chk(int'(grant_id_o) == exp_gid, "R10 grant id", int'(grant_id_o), exp_gid);
      chk(int'(reject_o) == exp_rej, "R6 reject", int'(reject_o), exp_rej);
      ph = phase_of(cyc);
      if (ph != prev_ph && have) begin idused[d_id] = 0; have = 0; end
      prev_ph = ph;
      // completions
      done_i = '0;
      for (int u = 0; u < NCU; u++) begin
        bit go;
        go = (ph % 2 == 1) ? ($urandom % 2 == 0) : (ph == 6 && $urandom % 6 == 0);
        if (go) begin
          int st;
          st = $urandom % NID;
          for (int k = 0; k < NID; k++) begin
            int id;
            id = (st + k) % NID;
            if (!done_i[u] && res[u][id]) begin
              done_i[u] = 1'b1;
              done_id_i[u*IDW +: IDW] = IDW'(id);
            end
          end
        end
      end
      // descriptor source
      if (!have && ph % 2 == 0) begin
        for (int i = 0; i < NID; i++)
          if (!have && !idused[i]) begin have = 1; d_id = i; idused[i] = 1; end
        if (have) begin
          if (ph == 0)      begin d_thr = 65;  d_rpt = 1;  d_smem = 0; end
          else if (ph == 2) begin d_thr = 256; d_rpt = 64; d_smem = 0; end
          else if (ph == 4) begin d_thr = 32;  d_rpt = 1;  d_smem = 20000; end
          else begin
            d_thr = $urandom % 1100; d_rpt = 1 + $urandom % 80; d_smem = $urandom % 30000;
            if ($urandom % 10 == 0) d_thr = 2049 + $urandom % 1500;
            if ($urandom % 15 == 0) d_smem = MSMEM + 1 + $urandom % 1000;
          end
        end
      end
      req_valid_i = have;
      req_id_i = IDW'(d_id); req_thr_i = 12'(d_thr);
      req_rpt_i = 8'(d_rpt); req_smem_i = 18'(d_smem);
      #1;
      // model decision
      w = (d_thr + 31) / 32;
      rg = d_thr * d_rpt;
      ovs = (d_thr == 0 || w > MWARP || d_thr > MTHR || rg > MREG || d_smem > MSMEM) ? 1 : 0;
      pick = -1;
      for (int u = 0; u < NCU; u++)
        fits[u] = fb[u] >= 1 && fw[u] >= w && ft[u] >= d_thr && fr[u] >= rg && fs[u] >= d_smem;
      for (int k = 1; k <= NCU; k++)
        if (pick < 0 && fits[(last + k) % NCU]) pick = (last + k) % NCU;
      if (have)
        chk(req_ready_o == (ovs == 1 || pick >= 0), "R1 R2 R3 R5 R7 R9 ready",
            int'(req_ready_o), (ovs == 1 || pick >= 0) ? 1 : 0);
      exp_gv = 0; exp_rej = 0; exp_gid = d_id;
      // release first
      for (int u = 0; u < NCU; u++)
        if (done_i[u]) begin
          int id;
          id = int'(done_id_i[u*IDW +: IDW]);
          fb[u]++; fw[u] += tw[u][id]; ft[u] += tt[u][id]; fr[u] += tr[u][id]; fs[u] += ts[u][id];
          res[u][id] = 0; idused[id] = 0;
        end
      if (have) begin
        if (ovs == 1) begin
          exp_rej = 1; idused[d_id] = 0; have = 0;
        end else if (pick >= 0) begin
          exp_gv = 1 << pick; last = pick;
          fb[pick]--; fw[pick] -= w; ft[pick] -= d_thr; fr[pick] -= rg; fs[pick] -= d_smem;
          tw[pick][d_id] = w; tt[pick][d_id] = d_thr; tr[pick][d_id] = rg; ts[pick][d_id] = d_smem;
          res[pick][d_id] = 1; have = 0;
        end
      end
    end
    @(negedge clk);
    chk(int'(grant_vld_o) == exp_gv, "R10 final grant", int'(grant_vld_o), exp_gv);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule